// File: doc/BRIEF.md
# Weight-Coded Tour Decoder and Cost Accumulator

This block evaluates one candidate round trip through a fixed set of cities. The candidate arrives as a vector of per-city weights. Sorting those weights in ascending order gives the sequence in which the cities are visited. The block orders the weights with a systolic insertion array. It then reports two results: the visit sequence, and the rank of every city, which is the permutation that replaces the weights in storage. Finally it walks the tour and sums the directed travel costs, including the leg from the last city back to the first.

Travel costs are held in an internal N x N matrix indexed by (from, to), so the cost of a leg can depend on its direction. The matrix is loaded through an address/data/write-enable port while the block is idle. A one-cycle `start` pulse launches an evaluation, `busy` covers the run, and a one-cycle `done` pulse marks the cycle in which all three results become valid.

Top module: `tour_cost_eval`

## Requirements
- R1: While and after reset, `busy`, `done`, `tour_cost`, `visit_order` and `city_rank` are all zero.
- R2: The weight of city c is `weights[c*WEIGHT_W +: WEIGHT_W]`. `visit_order[i*IDX_W +: IDX_W]` is the city holding the i-th smallest weight. For weights 25,17,10,20,55,5,70,13 on cities 0..7, the visit order is 5,2,7,1,3,0,4,6.
- R3: When weights are equal, the city with the lower index comes earlier in the visit order, so the result is always a permutation of 0..N_CITY-1.
- R4: `city_rank[c*IDX_W +: IDX_W]` is the position of city c in the visit order. For the R2 example the ranks are 5,3,1,4,6,0,7,2.
- R5: `tour_cost` is the sum over i of cost(order[i], order[i+1]), where the leg after the last position returns to order[0]. Each cost is read from the matrix entry written with `cm_from` = source city and `cm_to` = destination city, and the two directions of a leg are independent entries.
- R6: `tour_cost` is COST_W+clog2(N_CITY) bits wide and does not overflow. With every entry at its maximum, it reads N_CITY*(2^COST_W-1).
- R7: `done` is high for exactly one cycle. That cycle comes 3*N_CITY+1 clock edges after the edge that accepted `start`. `busy` is high from the accepting edge up to, but not including, the `done` cycle.
- R8: A `start` while `busy` is high is ignored. The weights are captured at the accepting edge, so later changes on `weights` do not affect the running evaluation.
- R9: A matrix write while `busy` is high is discarded. A write while idle is used by every later evaluation.
- R10: `tour_cost`, `visit_order` and `city_rank` change only in a `done` cycle and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cm_we | input | 1 | Cost matrix write strobe |
| cm_from | input | IDX_W | Source city of the written entry |
| cm_to | input | IDX_W | Destination city of the written entry |
| cm_data | input | COST_W | Cost value to write |
| start | input | 1 | Launches an evaluation when idle |
| weights | input | N_CITY*WEIGHT_W | Per-city weights, city c at slice c |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| tour_cost | output | SUM_W | Total directed cost of the closed tour |
| visit_order | output | N_CITY*IDX_W | City at each tour position |
| city_rank | output | N_CITY*IDX_W | Tour position of each city |

## Verification
Any fault in the sorting cells shows up at the next `done` as a visit order that is out of ascending weight order, or as one that is not a permutation. Because the ranks and the cost are derived from that order, they go wrong in the same cycle. A phase counter that is off by one moves the `done` pulse away from the fixed distance of 3*N_CITY+1 edges. A stale or miscleared accumulator corrupts `tour_cost` in the very next result. A matrix write that slips through while `busy` is high changes the cost of the evaluation already in flight, so it shows up at its `done` cycle.

// File: rtl/tour_cost_pkg.sv
`timescale 1ns/1ps
package tour_cost_pkg;
   // Evaluation phases; each of LOAD, SETTLE and WALK lasts N_CITY cycles.
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SETTLE,
      ST_WALK,
      ST_TAIL
   } eval_state_e;
endpackage

// File: rtl/tce_sort_array.sv
`timescale 1ns/1ps
// Systolic insertion array: each cell keeps the smaller of its held pair and
// the arriving pair, and passes the larger one to its neighbour on the next edge.
module tce_sort_array #(
   parameter int NCELL = 8,
   parameter int KEY_W = 8,
   parameter int ID_W  = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   in_vld,
   input  logic [KEY_W-1:0]       in_key,
   input  logic [ID_W-1:0]        in_id,
   output logic [NCELL*ID_W-1:0]  cell_id
);
   localparam int PW = KEY_W + ID_W;

   logic [PW-1:0] hold_w [NCELL];
   logic          hv_w   [NCELL];
   logic [PW-1:0] fwd_w  [NCELL];
   logic          fv_w   [NCELL];

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      logic [PW-1:0] arr;
      logic          arr_v;
      logic [PW-1:0] hold;
      logic          hold_v;
      logic [PW-1:0] fwd;
      logic          fwd_v;

      if (i == 0) begin : g_head
         // city index in the low bits breaks ties toward the lower city
         assign arr   = {in_key, in_id};
         assign arr_v = in_vld;
      end else begin : g_body
         assign arr   = fwd_w[i-1];
         assign arr_v = fv_w[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold   <= '0;
            hold_v <= 1'b0;
            fwd    <= '0;
            fwd_v  <= 1'b0;
         end else if (clr) begin
            hold_v <= 1'b0;
            fwd_v  <= 1'b0;
         end else begin
            fwd_v <= 1'b0;
            if (arr_v) begin
               if (!hold_v) begin
                  hold   <= arr;
                  hold_v <= 1'b1;
               end else if (arr < hold) begin
                  hold  <= arr;
                  fwd   <= hold;
                  fwd_v <= 1'b1;
               end else begin
                  fwd   <= arr;
                  fwd_v <= 1'b1;
               end
            end
         end
      end

      assign hold_w[i] = hold;
      assign hv_w[i]   = hold_v;
      assign fwd_w[i]  = fwd;
      assign fv_w[i]   = fwd_v;
      assign cell_id[i*ID_W +: ID_W] = hold[ID_W-1:0];
   end

   // R2: occupied neighbours are always in strictly ascending (weight, city) order
   for (genvar i = 0; i < NCELL - 1; i++) begin : g_chk
      a_r2_cells_ascending: assert property (@(posedge clk) disable iff (!rst_n)
         (hv_w[i] && hv_w[i+1]) |-> (hold_w[i] < hold_w[i+1]));
   end

   // R2: with N_CITY pairs per clear, nothing is ever pushed out of the last cell
   a_r2_no_spill: assert property (@(posedge clk) disable iff (!rst_n)
      !fv_w[NCELL-1]);
endmodule

// File: rtl/tce_cost_mem.sv
`timescale 1ns/1ps
// Directed cost matrix, one write and one registered read per cycle.
module tce_cost_mem #(
   parameter int N_CITY = 8,
   parameter int COST_W = 8,
   localparam int IDX_W = $clog2(N_CITY),
   localparam int DEPTH = N_CITY * N_CITY,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_from,
   input  logic [IDX_W-1:0]  wr_to,
   input  logic [COST_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_from,
   input  logic [IDX_W-1:0]  rd_to,
   output logic [COST_W-1:0] rd_data
);
   logic [COST_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wa;
   logic [AW-1:0]     ra;

   // address variant: plain concatenation for power-of-two city counts
   if ((N_CITY & (N_CITY - 1)) == 0) begin : g_pow2
      assign wa = {wr_from, wr_to};
      assign ra = {rd_from, rd_to};
   end else begin : g_mul
      assign wa = AW'(int'(wr_from) * N_CITY + int'(wr_to));
      assign ra = AW'(int'(rd_from) * N_CITY + int'(rd_to));
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wa] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= mem[ra];
   end
endmodule

// File: rtl/tce_rank_invert.sv
`timescale 1ns/1ps
// Inverts a visit order into a per-city position vector.
module tce_rank_invert #(
   parameter int N_CITY = 8,
   localparam int IDX_W = $clog2(N_CITY)
) (
   input  logic [N_CITY*IDX_W-1:0] order,
   output logic [N_CITY*IDX_W-1:0] rank
);
   always_comb begin
      rank = '0;
      for (int i = 0; i < N_CITY; i++) begin
         for (int c = 0; c < N_CITY; c++) begin
            if (int'(order[i*IDX_W +: IDX_W]) == c)
               rank[c*IDX_W +: IDX_W] = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/tour_cost_eval.sv
`timescale 1ns/1ps
module tour_cost_eval
   import tour_cost_pkg::*;
#(
   parameter int N_CITY   = 8,
   parameter int WEIGHT_W = 8,
   parameter int COST_W   = 8,
   localparam int IDX_W   = $clog2(N_CITY),
   localparam int SUM_W   = COST_W + $clog2(N_CITY)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cm_we,
   input  logic [IDX_W-1:0]        cm_from,
   input  logic [IDX_W-1:0]        cm_to,
   input  logic [COST_W-1:0]       cm_data,
   input  logic                    start,
   input  logic [N_CITY*WEIGHT_W-1:0] weights,
   output logic                    busy,
   output logic                    done,
   output logic [SUM_W-1:0]        tour_cost,
   output logic [N_CITY*IDX_W-1:0] visit_order,
   output logic [N_CITY*IDX_W-1:0] city_rank
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CITY - 1);
   localparam int LAT   = 3 * N_CITY + 1;
   localparam int CHK_W = $clog2(LAT + 1) + 1;

   if (N_CITY < 2) begin : g_bad_cities
      $error("tour_cost_eval: N_CITY must be at least 2");
   end
   if (N_CITY > 64) begin : g_big_cities
      $error("tour_cost_eval: N_CITY above 64 makes the matrix too large");
   end
   if (WEIGHT_W < 1 || COST_W < 1) begin : g_bad_width
      $error("tour_cost_eval: WEIGHT_W and COST_W must be positive");
   end

   eval_state_e               state;
   logic [IDX_W-1:0]          cnt;
   logic [IDX_W-1:0]          nxt;
   logic [N_CITY*WEIGHT_W-1:0] wreg;
   logic [SUM_W-1:0]          acc;
   logic                      qv;
   logic                      accept;
   logic [N_CITY*IDX_W-1:0]   sorted_id;
   logic [N_CITY*IDX_W-1:0]   rank_w;
   logic [COST_W-1:0]         rd_cost;
   logic [IDX_W-1:0]          leg_from;
   logic [IDX_W-1:0]          leg_to;

   assign busy   = (state != ST_IDLE);
   assign accept = (state == ST_IDLE) && start;
   assign nxt    = (cnt == LAST_IDX) ? '0 : cnt + 1'b1;

   tce_sort_array #(
      .NCELL (N_CITY),
      .KEY_W (WEIGHT_W),
      .ID_W  (IDX_W)
   ) i_sort (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .in_vld  (state == ST_LOAD),
      .in_key  (wreg[int'(cnt)*WEIGHT_W +: WEIGHT_W]),
      .in_id   (cnt),
      .cell_id (sorted_id)
   );

   assign leg_from = sorted_id[int'(cnt)*IDX_W +: IDX_W];
   assign leg_to   = sorted_id[int'(nxt)*IDX_W +: IDX_W];

   tce_cost_mem #(
      .N_CITY (N_CITY),
      .COST_W (COST_W)
   ) i_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cm_we && !busy),
      .wr_from (cm_from),
      .wr_to   (cm_to),
      .wr_data (cm_data),
      .rd_from (leg_from),
      .rd_to   (leg_to),
      .rd_data (rd_cost)
   );

   tce_rank_invert #(
      .N_CITY (N_CITY)
   ) i_rank (
      .order (sorted_id),
      .rank  (rank_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         wreg        <= '0;
         acc         <= '0;
         qv          <= 1'b0;
         done        <= 1'b0;
         tour_cost   <= '0;
         visit_order <= '0;
         city_rank   <= '0;
      end else begin
         done <= 1'b0;
         qv   <= (state == ST_WALK);
         if (qv) acc <= acc + SUM_W'(rd_cost);
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  wreg  <= weights;
                  cnt   <= '0;
                  acc   <= '0;
                  state <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               cnt <= nxt;
               if (cnt == LAST_IDX) state <= ST_SETTLE;
            end
            ST_SETTLE: begin
               cnt <= nxt;
               if (cnt == LAST_IDX) state <= ST_WALK;
            end
            ST_WALK: begin
               cnt <= nxt;
               if (cnt == LAST_IDX) state <= ST_TAIL;
            end
            ST_TAIL: begin
               tour_cost   <= acc + SUM_W'(rd_cost);
               visit_order <= sorted_id;
               city_rank   <= rank_w;
               done        <= 1'b1;
               state       <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   logic [CHK_W-1:0]  chk_cnt;
   logic [N_CITY-1:0] seen;
   logic              rank_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chk_cnt <= '0;
      else if (accept) chk_cnt <= '0;
      else if (busy)   chk_cnt <= chk_cnt + 1'b1;
   end

   always_comb begin
      seen    = '0;
      rank_ok = 1'b1;
      for (int i = 0; i < N_CITY; i++) begin
         for (int c = 0; c < N_CITY; c++) begin
            if (int'(visit_order[i*IDX_W +: IDX_W]) == c) begin
               seen[c] = 1'b1;
               if (int'(city_rank[c*IDX_W +: IDX_W]) != i) rank_ok = 1'b0;
            end
         end
      end
   end

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (chk_cnt == CHK_W'(LAT)));
   a_r3_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones(seen) == N_CITY));
   a_r4_rank_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> rank_ok);
   a_r8_weights_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(wreg));
   a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(tour_cost) && $stable(visit_order) && $stable(city_rank)));
endmodule

// File: tb/test_tour_cost_eval.sv
`timescale 1ns/1ps
module test_tour_cost_eval;
   localparam int N  = 8;
   localparam int WW = 8;
   localparam int CW = 8;
   localparam int IW = 3;
   localparam int SW = CW + 3;

   typedef struct packed {
      logic [SW-1:0]   cost;
      logic [N*IW-1:0] ord;
      logic [N*IW-1:0] rnk;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cm_we = 1'b0;
   logic [IW-1:0]   cm_from = '0;
   logic [IW-1:0]   cm_to = '0;
   logic [CW-1:0]   cm_data = '0;
   logic            start = 1'b0;
   logic [N*WW-1:0] weights = '0;
   logic            busy;
   logic            done;
   logic [SW-1:0]   tour_cost;
   logic [N*IW-1:0] visit_order;
   logic [N*IW-1:0] city_rank;

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   int    start_cyc = 0;
   int    cost_m [N][N];
   exp_t  q [$];
   string tag_q [$];
   exp_t  last_exp;

   tour_cost_eval #(.N_CITY(N), .WEIGHT_W(WW), .COST_W(CW)) i_tour_cost_eval (
      .clk(clk), .rst_n(rst_n), .cm_we(cm_we), .cm_from(cm_from), .cm_to(cm_to),
      .cm_data(cm_data), .start(start), .weights(weights), .busy(busy), .done(done),
      .tour_cost(tour_cost), .visit_order(visit_order), .city_rank(city_rank));

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string what, input longint got, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %0h exp %0h", what, got, expv);
      end
   endtask

   function automatic logic [N*IW-1:0] pack_idx(input int a [N]);
      logic [N*IW-1:0] r = '0;
      for (int i = 0; i < N; i++) r[i*IW +: IW] = IW'(a[i]);
      return r;
   endfunction

   function automatic logic [N*WW-1:0] pack_w(input int a [N]);
      logic [N*WW-1:0] r = '0;
      for (int i = 0; i < N; i++) r[i*WW +: WW] = WW'(a[i]);
      return r;
   endfunction

   // reference model: stable selection by ascending weight, lower city first on ties
   task automatic predict(input logic [N*WW-1:0] w, input string tag);
      int   ordv [N];
      int   rnkv [N];
      bit   used [N];
      int   sum = 0;
      exp_t e;
      for (int c = 0; c < N; c++) used[c] = 1'b0;
      for (int p = 0; p < N; p++) begin
         int best = -1;
         for (int c = 0; c < N; c++)
            if (!used[c] && (best < 0 || w[c*WW +: WW] < w[best*WW +: WW])) best = c;
         used[best] = 1'b1;
         ordv[p] = best;
         rnkv[best] = p;
      end
      for (int p = 0; p < N; p++) sum += cost_m[ordv[p]][ordv[(p + 1) % N]];
      e.cost = SW'(sum);
      e.ord  = pack_idx(ordv);
      e.rnk  = pack_idx(rnkv);
      q.push_back(e);
      tag_q.push_back(tag);
      last_exp = e;
   endtask

   task automatic wr_cost(input int f, input int t, input int d, input bit model);
      @(negedge clk);
      cm_we = 1'b1; cm_from = IW'(f); cm_to = IW'(t); cm_data = CW'(d);
      @(negedge clk);
      cm_we = 1'b0;
      if (model) cost_m[f][t] = d;
   endtask

   // noisy: an ignored start with other weights plus a discarded matrix write mid-run
   task automatic run_eval(input logic [N*WW-1:0] w, input string tag, input bit noisy);
      predict(w, tag);
      @(negedge clk);
      weights = w; start = 1'b1; start_cyc = cyc;
      @(negedge clk);
      start = 1'b0;
      if (noisy) begin
         @(negedge clk);
         @(negedge clk);
         weights = ~w; start = 1'b1;
         cm_we = 1'b1; cm_from = 3'd5; cm_to = 3'd2; cm_data = CW'(cost_m[5][2] ^ 8'h5A);
         @(negedge clk);
         start = 1'b0; cm_we = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      exp_t  e;
      string t;
      if (rst_n && done) begin
         if (q.size() == 0) begin
            check(1'b0, "R8 unexpected done pulse", 1, 0);
         end else begin
            e = q.pop_front();
            t = tag_q.pop_front();
            check(tour_cost == e.cost, $sformatf("%s R5 tour cost", t), tour_cost, e.cost);
            check(visit_order == e.ord, $sformatf("%s R2 visit order", t), visit_order, e.ord);
            check(city_rank == e.rnk, $sformatf("%s R4 city rank", t), city_rank, e.rnk);
            // 3N+1 edges after the accepting edge, one more counted from the drive point
            check((cyc - start_cyc) == 3 * N + 2, $sformatf("%s R7 done latency", t),
                  cyc - start_cyc, 3 * N + 2);
         end
      end
   end

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired got hung exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ex_w   [N] = '{25, 17, 10, 20, 55, 5, 70, 13};
      int ex_ord [N] = '{5, 2, 7, 1, 3, 0, 4, 6};
      int ex_rnk [N] = '{5, 3, 1, 4, 6, 0, 7, 2};
      int tie_w  [N] = '{9, 4, 9, 4, 1, 9, 1, 4};
      int asc_w  [N] = '{0, 10, 20, 30, 40, 50, 60, 70};
      int dsc_w  [N] = '{70, 60, 50, 40, 30, 20, 10, 0};
      logic [N*WW-1:0] rw;
      int busy_seen;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
      check(tour_cost == '0 && visit_order == '0 && city_rank == '0, "R1 results in reset",
            tour_cost, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && tour_cost == '0, "R1 after release", busy, 0);

      for (int f = 0; f < N; f++)
         for (int t = 0; t < N; t++) wr_cost(f, t, int'($urandom_range(255)), 1'b1);

      // R2 R4: worked example
      run_eval(pack_w(ex_w), "R2 example", 1'b0);
      check(visit_order == pack_idx(ex_ord), "R2 example fixed order", visit_order, pack_idx(ex_ord));
      check(city_rank == pack_idx(ex_rnk), "R4 example fixed ranks", city_rank, pack_idx(ex_rnk));

      // R3: ties
      run_eval('0, "R3 all equal", 1'b0);
      check(visit_order == pack_idx('{0, 1, 2, 3, 4, 5, 6, 7}), "R3 all equal identity",
            visit_order, pack_idx('{0, 1, 2, 3, 4, 5, 6, 7}));
      run_eval(pack_w(tie_w), "R3 paired ties", 1'b0);

      // R5: both directions of the same cycle use different matrix entries
      run_eval(pack_w(asc_w), "R5 ascending", 1'b0);
      run_eval(pack_w(dsc_w), "R5 descending", 1'b0);

      // R8 R9: start and write during busy are ignored
      busy_seen = 0;
      run_eval(pack_w(ex_w), "R8 R9 noisy run", 1'b1);
      repeat (3 * N + 6) @(negedge clk);
      check(q.size() == 0 && busy == 1'b0, "R8 no restart after ignored start", busy, 0);

      // R9: idle write takes effect
      wr_cost(5, 2, cost_m[5][2] ^ 8'h33, 1'b1);
      run_eval(pack_w(ex_w), "R9 idle write used", 1'b0);

      // R2 R4 R5: random candidates
      for (int k = 0; k < 5; k++) begin
         for (int c = 0; c < N; c++) rw[c*WW +: WW] = WW'($urandom_range(255));
         run_eval(rw, $sformatf("R2 random %0d", k), 1'b0);
      end

      // R10: results hold while idle and inputs move
      weights = ~weights;
      repeat (7) @(negedge clk);
      check(tour_cost == last_exp.cost, "R10 cost held", tour_cost, last_exp.cost);
      check(visit_order == last_exp.ord && city_rank == last_exp.rnk, "R10 order/rank held",
            visit_order, last_exp.ord);

      // R6: every cost at its maximum
      for (int f = 0; f < N; f++)
         for (int t = 0; t < N; t++) wr_cost(f, t, 255, 1'b1);
      run_eval(pack_w(ex_w), "R6 max costs", 1'b0);
      check(tour_cost == SW'(N * 255), "R6 full-scale sum", tour_cost, N * 255);

      repeat (4) @(negedge clk);
      check(q.size() == 0, "R7 all expected results seen", q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule